// File: doc/BRIEF.md
# Partitioned Pixel-by-Scale Multiplier

This block is a SIMD multiply stage for 64-bit operands. It multiplies 8-bit pixel values taken from operand A by signed 16-bit scale factors taken from operand B, and it rounds each product. A 3-bit opcode picks one of seven ways of pairing the sub-lanes of the two operands.

Five opcodes return four 16-bit lane results. Two opcodes return two 32-bit products. The result sits in an output register, and a valid flag marks it one clock after the request.

The block sits in an execution pipeline. The issue logic presents both operands, the opcode and a one-cycle valid strobe. It takes the result on the following cycle.

Top module: `vmul8x16`

## Requirements
- R1: Opcode 0 (per-lane): for each lane r in 0..3, signed B[16r+15:16r] is multiplied by unsigned A[8r+7:8r] (byte r of A). The rounded product bits [23:8] are placed in res_o[16r+15:16r].
- R2: Rounding: the product is treated as a 32-bit two's-complement value. When its bits [7:0] exceed 0x7F, 0x100 is added before the result field is taken. Examples for opcode 0: B lane 0 = 1 with A byte 0 = 0x80 gives lane 0 = 0x0001. The same B lane with A byte 0 = 0x7F gives 0x0000. B lane 0 = 0xFFFF with A byte 0 = 0x01 gives 0x0000.
- R3: Opcode 1 uses signed B[31:16] as the scale for all four lanes. Byte r of A is the pixel, as in R1.
- R4: Opcode 2 uses signed B[15:0] as the scale for all four lanes. Byte r of A is the pixel.
- R5: Opcode 3 multiplies signed B lane r by the signed high byte of A lane r, which is A[16r+15:16r] shifted right arithmetically by 8. The result is placed as in R1.
- R6: Opcode 4 multiplies signed B lane r by the unsigned low byte A[16r+7:16r]. The result is placed as in R1.
- R7: Opcode 5 computes lanes 0 and 1 with the pairing of R5. The whole 32-bit rounded product of lane r is placed in res_o[32r+31:32r].
- R8: Opcode 6 computes lanes 0 and 1 with the pairing of R6. The 32-bit results are placed as in R7.
- R9: Opcode 7 is unused and yields an all-zero result.
- R10: A request with valid_i high loads res_o at the next rising clock edge. valid_o is high for exactly the cycle after each cycle in which valid_i is high.
- R11: While valid_i is low, res_o holds its last value whatever a_i, b_i and op_i do.
- R12: When rst_ni is low, valid_o and res_o are cleared to zero at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Variant select, 0 to 6; 7 is unused |
| a_i | input | 64 | Pixel operand |
| b_i | input | 64 | Scale operand |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| res_o | output | 64 | Registered result |

## Verification
The assertions assume that the inputs are known whenever valid_i is high. They also assume that reset is released away from a clock edge.

The stimulus follows both assumptions:
- Inputs change only on the falling edge.
- Reset is released on a falling edge.
- valid_i is held for a single cycle and then dropped.

This lets each result be checked and then checked again for R11 while the operands are scrambled.

The sweep covers every opcode with all 256 values of one pixel byte. It pairs these with scale values that include both extremes of the signed range, zero and ±1.

// File: rtl/vmul_pkg.sv
package vmul_pkg;
  typedef enum logic [2:0] {
    OP_LANE = 3'd0,
    OP_BC1  = 3'd1,
    OP_BC0  = 3'd2,
    OP_HI8  = 3'd3,
    OP_LO8  = 3'd4,
    OP_DHI8 = 3'd5,
    OP_DLO8 = 3'd6,
    OP_NONE = 3'd7
  } vmul_op_e;

  function automatic logic is_dual(input logic [2:0] op);
    return (op == OP_DHI8) || (op == OP_DLO8);
  endfunction
endpackage

// File: rtl/vmul_operand_sel.sv
module vmul_operand_sel
  import vmul_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 16,
  localparam int PIX_W    = LANE_W / 2,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic [2:0]                         op_i,
  input  logic [DATA_W-1:0]                  a_i,
  input  logic [DATA_W-1:0]                  b_i,
  output logic [NUM_LANES-1:0][LANE_W-1:0]   scale_o,
  output logic [NUM_LANES-1:0][PIX_W:0]      pix_o
);
  for (genvar r = 0; r < NUM_LANES; r++) begin : g_lane
    logic [LANE_W-1:0] b_lane, a_lane;
    logic [PIX_W-1:0]  a_byte;
    assign b_lane = b_i[r*LANE_W +: LANE_W];
    assign a_lane = a_i[r*LANE_W +: LANE_W];
    assign a_byte = a_i[r*PIX_W +: PIX_W];

    always_comb begin
      scale_o[r] = '0;
      pix_o[r]   = '0;
      unique case (op_i)
        OP_LANE: begin
          scale_o[r] = b_lane;
          pix_o[r]   = {1'b0, a_byte};
        end
        OP_BC1: begin
          scale_o[r] = b_i[LANE_W +: LANE_W];
          pix_o[r]   = {1'b0, a_byte};
        end
        OP_BC0: begin
          scale_o[r] = b_i[0 +: LANE_W];
          pix_o[r]   = {1'b0, a_byte};
        end
        OP_HI8, OP_DHI8: begin
          scale_o[r] = b_lane;
          pix_o[r]   = {a_lane[LANE_W-1], a_lane[LANE_W-1 -: PIX_W]};
        end
        OP_LO8, OP_DLO8: begin
          scale_o[r] = b_lane;
          pix_o[r]   = {1'b0, a_lane[PIX_W-1:0]};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vmul_lane.sv
module vmul_lane #(
  parameter int LANE_W   = 16,
  localparam int PIX_W   = LANE_W / 2,
  localparam int PROD_W  = 2 * LANE_W
) (
  input  logic [LANE_W-1:0] scale_i,
  input  logic [PIX_W:0]    pix_i,
  output logic [PROD_W-1:0] rnd_o
);
  logic signed [PROD_W-1:0] scale_x, pix_x, prod;
  logic [PROD_W-1:0]        bias;

  assign scale_x = {{(PROD_W-LANE_W){scale_i[LANE_W-1]}}, scale_i};
  assign pix_x   = {{(PROD_W-PIX_W-1){pix_i[PIX_W]}}, pix_i};
  assign prod    = scale_x * pix_x;
  // low byte above half -> bias into bit PIX_W
  assign bias    = {{(PROD_W-PIX_W-1){1'b0}}, prod[PIX_W-1], {PIX_W{1'b0}}};
  assign rnd_o   = prod + bias;
endmodule

// File: rtl/vmul_pack.sv
module vmul_pack
  import vmul_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 16,
  localparam int PIX_W    = LANE_W / 2,
  localparam int PROD_W   = 2 * LANE_W,
  localparam int DATA_W   = NUM_LANES * LANE_W,
  localparam int DUAL_N   = NUM_LANES / 2
) (
  input  logic [2:0]                         op_i,
  input  logic [NUM_LANES-1:0][PROD_W-1:0]   rnd_i,
  output logic [DATA_W-1:0]                  res_o
);
  logic [DATA_W-1:0] narrow, wide;

  for (genvar r = 0; r < NUM_LANES; r++) begin : g_narrow
    assign narrow[r*LANE_W +: LANE_W] = rnd_i[r][PIX_W +: LANE_W];
  end
  for (genvar r = 0; r < DUAL_N; r++) begin : g_wide
    assign wide[r*PROD_W +: PROD_W] = rnd_i[r];
  end
  if (DUAL_N * PROD_W < DATA_W) begin : g_wide_pad
    assign wide[DATA_W-1:DUAL_N*PROD_W] = '0;
  end

  always_comb begin
    if (op_i == OP_NONE)   res_o = '0;
    else if (is_dual(op_i)) res_o = wide;
    else                   res_o = narrow;
  end
endmodule

// File: rtl/vmul8x16.sv
module vmul8x16 #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 16,
  localparam int PIX_W    = LANE_W / 2,
  localparam int PROD_W   = 2 * LANE_W,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o
);
  logic [NUM_LANES-1:0][LANE_W-1:0] scale;
  logic [NUM_LANES-1:0][PIX_W:0]    pix;
  logic [NUM_LANES-1:0][PROD_W-1:0] rnd;
  logic [DATA_W-1:0]                res_d;

  vmul_operand_sel #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_sel (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .scale_o(scale), .pix_o(pix)
  );

  for (genvar r = 0; r < NUM_LANES; r++) begin : g_mul
    vmul_lane #(.LANE_W(LANE_W)) u_lane (
      .scale_i(scale[r]), .pix_i(pix[r]), .rnd_o(rnd[r])
    );
  end

  vmul_pack #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_pack (
    .op_i(op_i), .rnd_i(rnd), .res_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_o <= res_d;
    end
  end
endmodule

// File: rtl/vmul8x16_chk.sv
module vmul8x16_chk #(
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 16,
  localparam int PIX_W    = LANE_W / 2,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] res_o
);
  logic a_flat;
  assign a_flat = (a_i == {(2*NUM_LANES){a_i[PIX_W-1:0]}});

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && res_o == '0));  // R12
  AST_VALID_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);  // R10
  AST_VALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);  // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o));  // R11
  AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd7) |=> res_o == '0);  // R9
  AST_BCAST_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd1 || op_i == 3'd2) && a_flat)
      |=> res_o == {NUM_LANES{res_o[LANE_W-1:0]}});  // R3
  AST_ZERO_PIXEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && a_i == '0) |=> res_o == '0);  // R2
  AST_ZERO_SCALE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd6 && b_i == '0) |=> res_o == '0);  // R8
endmodule

bind vmul8x16 vmul8x16_chk #(.NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/tb_vmul8x16.sv
module tb_vmul8x16;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] a_i = '0;
  logic [63:0] b_i = '0;
  logic        valid_o;
  logic [63:0] res_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  vmul8x16 dut (.*);

  function automatic logic [31:0] rnd32(input int p);
    logic [31:0] t;
    t = p;
    if (t[7:0] > 8'h7f) t = t + 32'h100;
    return t;
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    for (int l = 0; l < 4; l++) begin
      int sc, px;
      logic [31:0] t;
      logic [15:0] al;
      al = a[16*l +: 16];
      case (op)
        3'd1:    sc = $signed(b[31:16]);
        3'd2:    sc = $signed(b[15:0]);
        default: sc = $signed(b[16*l +: 16]);
      endcase
      case (op)
        3'd3, 3'd5: px = $signed(al[15:8]);
        3'd4, 3'd6: px = int'(al[7:0]);
        default:    px = int'(a[8*l +: 8]);
      endcase
      t = rnd32(sc * px);
      if (op <= 3'd4) r[16*l +: 16] = t[23:8];
      else if (op != 3'd7 && l < 2) r[32*l +: 32] = t;
    end
    return r;
  endfunction

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] op, input logic [63:0] a,
                       input logic [63:0] b);
    logic [63:0] exp;
    exp = model(op, a, b);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
    check64(tag, res_o, exp);
    check64("R10 valid", {63'd0, valid_o}, 64'd1);
    a_i = ~a; b_i = ~b; op_i = op ^ 3'd5;
    @(negedge clk_i);
    check64("R11 hold", res_o, exp);
    check64("R10 drop", {63'd0, valid_o}, 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] seed;
    logic [15:0] sv[8];
    seed = 64'h1234_5678_9abc_def0;
    sv[0] = 16'h8000; sv[1] = 16'h7fff; sv[2] = 16'h0000; sv[3] = 16'hffff;
    sv[4] = 16'h0001; sv[5] = 16'h0100; sv[6] = 16'h00ff; sv[7] = 16'h8001;

    repeat (3) @(negedge clk_i);
    check64("R12 reset res", res_o, 64'd0);
    check64("R12 reset valid", {63'd0, valid_o}, 64'd0);
    rst_ni = 1'b1;

    // R2 rounding corners
    apply("R2 up", 3'd0, 64'h80, 64'h1);
    check64("R2 up lane", res_o, 64'h1);
    apply("R2 down", 3'd0, 64'h7f, 64'h1);
    check64("R2 down lane", res_o, 64'h0);
    apply("R2 neg", 3'd0, 64'h01, 64'hffff);
    check64("R2 neg lane", res_o, 64'h0);
    apply("R2 wide", 3'd5, 64'hff00, 64'hffff);

    for (int op = 0; op < 8; op++) begin
      for (int i = 0; i < 256; i++) begin
        logic [63:0] a, b;
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        a = seed;
        seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
        b = seed;
        a[8*(i%8) +: 8] = i[7:0];
        a[15:8] = 8'(255 - i);
        b[16*(i%4) +: 16] = sv[i%8];
        b[31:16] = sv[(i+3)%8];
        apply(op_tag(op[2:0]), op[2:0], a, b);
      end
    end

    // R12 asynchronous clear mid-run
    apply("R1", 3'd0, 64'h0102_0304_0506_0708, 64'h0100_0100_0100_0100);
    #1 rst_ni = 1'b0;
    #1 check64("R12 async", res_o, 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule